// File: doc/BRIEF.md
# AAL5 Cell Segmentation Transmitter

This block cuts one AAL5 PDU byte stream into a run of 53-byte ATM cells that all carry the same stored four-byte header. Software or a controller first writes six configuration bytes: the four header bytes and then the 16-bit payload length. The sixth byte starts the PDU. For every cell the block sends the four header bytes, then a computed HEC byte, then 48 payload bytes. It pulls the payload bytes from an upstream FIFO with a valid/ready handshake.

Alongside each output byte the block drives a scramble-enable flag, which a downstream scrambler uses to leave the header and HEC unscrambled. It also drives a ninth end-of-PDU bit, which marks only the final byte of the final cell. In the last cell's header the block sets the end-of-message PTI bit and recomputes the HEC over the changed byte. It does not build the CPCS trailer, pad the PDU, compute the CRC-32 or scramble. The payload length it is given must be a non-zero multiple of 48. A PDU is normally two or more cells long.

Top module: `aal5_cell_seg`

## Requirements
- R1: While the block is idle, every cycle with `cfg_we` high takes `cfg_byte` as the next configuration byte. The order is header byte 0, byte 1, byte 2, byte 3, then the length high byte, then the length low byte. Taking the sixth byte starts the PDU. Configuration writes made while a PDU is being sent are ignored.
- R2: Each cell is 53 bytes long: header bytes 0 to 2 as loaded, header byte 3, the HEC byte, and then 48 payload bytes in the order the FIFO delivered them.
- R3: `out_scr_en` is low for the five header and HEC bytes of every cell and high for the 48 payload bytes.
- R4: The HEC byte is a CRC-8 with polynomial x^8+x^2+x+1 (0x07), initial value 0, taken most significant bit first over the four header bytes exactly as they are sent, then XORed with 0x55.
- R5: Header byte 3 is sent with bit 1 (mask 0x02) set in the last cell of the PDU and cleared in every earlier cell, whatever value was loaded for that bit. The other bits are sent as loaded.
- R6: A PDU of length L produces L/48 cells and takes exactly L payload bytes from the FIFO. A cell is the last one when 48 or fewer bytes remain at its start. After the last payload byte the block is idle: `out_valid` and `in_ready` are low and a new configuration can be loaded.
- R7: `out_eop` is high only with the 48th payload byte of the last cell and low for every other byte.
- R8: Bytes are transferred when `out_valid` and `out_ready` are both high. A header or HEC byte stays valid and unchanged while `out_ready` is low. During the payload, `in_ready` is low whenever `out_ready` is low, and `out_valid` is low while `in_valid` is low, so no byte is lost or repeated.
- R9: While reset is held, `out_valid`, `in_ready`, `out_scr_en` and `out_eop` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration byte strobe |
| cfg_byte | input | 8 | Configuration byte: four header bytes, then the length high and low bytes |
| in_valid | input | 1 | Upstream FIFO has a payload byte |
| in_data | input | 8 | Payload byte from the FIFO |
| in_ready | output | 1 | Payload byte is taken this cycle if valid |
| out_valid | output | 1 | Output byte is valid |
| out_data | output | 8 | Cell byte: header, HEC or payload |
| out_scr_en | output | 1 | High during payload bytes; the scrambler may act |
| out_eop | output | 1 | Ninth bit marking the final byte of the PDU |
| out_ready | input | 1 | Downstream accepts the output byte |

## Verification
The assertions check the cell framing on every cycle. They confirm that exactly five unscrambled bytes come before each run of payload and that no run is longer than 48 bytes. They also check that header and HEC bytes hold still under back-pressure, that payload bytes pass through unchanged, that the end-of-message bit matches the last-cell decision, and that the end-of-PDU marker falls on payload index 47 and is followed by idle. The byte values themselves can only be shown by the bench scenarios, which compare them with an independently built cell stream. These values are the HEC with its coset, the clearing of a pre-set end-of-message bit in earlier cells, the payload order, the cell count and the total bytes taken. The bench scenarios also show that configuration writes made during a PDU have no effect.

// File: rtl/aal5_seg_pkg.sv
package aal5_seg_pkg;

  localparam logic [7:0] HEC_POLY  = 8'h07;
  localparam logic [7:0] HEC_COSET = 8'h55;
  localparam logic [7:0] EOM_MASK  = 8'h02;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HDR,
    PH_HEC,
    PH_PAY
  } seg_phase_e;

  // one byte step of the header check, MSB first
  function automatic logic [7:0] hec_step(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c;
    c = crc ^ b;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ HEC_POLY) : (c << 1);
    end
    return c;
  endfunction

  // force the end-of-message bit to the last-cell decision
  function automatic logic [7:0] eom_patch(input logic [7:0] b, input logic last);
    return last ? (b | EOM_MASK) : (b & ~EOM_MASK);
  endfunction

endpackage

// File: rtl/seg_cfg_store.sv
module seg_cfg_store
  import aal5_seg_pkg::*;
#(
  parameter int unsigned HDR_BYTES    = 4,
  parameter int unsigned CELL_PAYLOAD = 48
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [7:0]                 cfg_byte,
  input  logic                       idle,
  input  logic                       cell_done,
  output logic [HDR_BYTES-1:0][7:0]  hdr_bytes,
  output logic                       last_cell,
  output logic                       pdu_start
);
  localparam int unsigned CFG_BYTES = HDR_BYTES + 2;
  localparam int unsigned CIDX_W    = $clog2(CFG_BYTES);
  localparam int unsigned LEN_W     = 16;
  localparam logic [LEN_W-1:0] CELL_LEN = LEN_W'(CELL_PAYLOAD);

  logic [CIDX_W-1:0] cfg_idx;
  logic [7:0]        len_hi;
  logic [LEN_W-1:0]  remain;
  logic              cfg_take;

  assign cfg_take  = cfg_we && idle;
  assign pdu_start = cfg_take && (cfg_idx == CIDX_W'(CFG_BYTES - 1));
  assign last_cell = (remain <= CELL_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_idx <= '0;
    end else if (cfg_take) begin
      cfg_idx <= pdu_start ? '0 : cfg_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_bytes <= '0;
      len_hi    <= '0;
    end else if (cfg_take) begin
      for (int i = 0; i < int'(HDR_BYTES); i++) begin
        if (cfg_idx == CIDX_W'(i)) hdr_bytes[i] <= cfg_byte;
      end
      if (cfg_idx == CIDX_W'(HDR_BYTES)) len_hi <= cfg_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (pdu_start) begin
      remain <= {len_hi, cfg_byte};
    end else if (cell_done) begin
      remain <= (remain > CELL_LEN) ? remain - CELL_LEN : '0;
    end
  end

endmodule

// File: rtl/seg_hec_acc.sv
module seg_hec_acc
  import aal5_seg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       step_en,
  input  logic [7:0] step_byte,
  output logic [7:0] hec_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hec_q <= '0;
    end else if (clear) begin
      hec_q <= '0;
    end else if (step_en) begin
      hec_q <= hec_step(hec_q, step_byte);
    end
  end

endmodule

// File: rtl/seg_cell_ctrl.sv
module seg_cell_ctrl
  import aal5_seg_pkg::*;
#(
  parameter int unsigned HDR_BYTES    = 4,
  parameter int unsigned CELL_PAYLOAD = 48,
  localparam int unsigned IDX_W       = $clog2(CELL_PAYLOAD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pdu_start,
  input  logic             last_cell,
  input  logic             in_valid,
  input  logic             out_ready,
  output seg_phase_e       phase,
  output logic [IDX_W-1:0] idx,
  output logic             hdr_xfer,
  output logic             cell_done
);
  seg_phase_e       phase_n;
  logic [IDX_W-1:0] idx_n;
  logic             hec_xfer, pay_xfer, hdr_end, pay_end;

  assign hdr_xfer  = (phase == PH_HDR) && out_ready;
  assign hec_xfer  = (phase == PH_HEC) && out_ready;
  assign pay_xfer  = (phase == PH_PAY) && in_valid && out_ready;
  assign hdr_end   = (idx == IDX_W'(HDR_BYTES - 1));
  assign pay_end   = (idx == IDX_W'(CELL_PAYLOAD - 1));
  assign cell_done = pay_xfer && pay_end;

  always_comb begin
    phase_n = phase;
    idx_n   = idx;
    unique case (phase)
      PH_IDLE: if (pdu_start) begin
        phase_n = PH_HDR;
        idx_n   = '0;
      end
      PH_HDR: if (hdr_xfer) begin
        if (hdr_end) begin
          phase_n = PH_HEC;
          idx_n   = '0;
        end else begin
          idx_n = idx + 1'b1;
        end
      end
      PH_HEC: if (hec_xfer) begin
        phase_n = PH_PAY;
        idx_n   = '0;
      end
      PH_PAY: if (pay_xfer) begin
        if (pay_end) begin
          phase_n = last_cell ? PH_IDLE : PH_HDR;
          idx_n   = '0;
        end else begin
          idx_n = idx + 1'b1;
        end
      end
      default: begin
        phase_n = PH_IDLE;
        idx_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      idx   <= '0;
    end else begin
      phase <= phase_n;
      idx   <= idx_n;
    end
  end

endmodule

// File: rtl/aal5_cell_seg.sv
module aal5_cell_seg
  import aal5_seg_pkg::*;
#(
  parameter int unsigned HDR_BYTES    = 4,
  parameter int unsigned CELL_PAYLOAD = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_byte,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_scr_en,
  output logic       out_eop,
  input  logic       out_ready
);
  localparam int unsigned IDX_W  = $clog2(CELL_PAYLOAD);
  localparam int unsigned HSEL_W = $clog2(HDR_BYTES);

  // named events shared with the bound checker
  seg_phase_e               phase;
  logic [IDX_W-1:0]         idx;
  logic [HDR_BYTES-1:0][7:0] hdr_bytes;
  logic                     last_cell;
  logic                     pdu_start;
  logic                     cell_done;
  logic                     hdr_xfer;
  logic [7:0]               hec_q;
  logic [7:0]               hdr_sel;
  logic [7:0]               hdr_tx;
  logic                     hdr_is_last;
  logic                     idle;

  assign idle = (phase == PH_IDLE);

  seg_cfg_store #(
    .HDR_BYTES   (HDR_BYTES),
    .CELL_PAYLOAD(CELL_PAYLOAD)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_byte (cfg_byte),
    .idle     (idle),
    .cell_done(cell_done),
    .hdr_bytes(hdr_bytes),
    .last_cell(last_cell),
    .pdu_start(pdu_start)
  );

  seg_cell_ctrl #(
    .HDR_BYTES   (HDR_BYTES),
    .CELL_PAYLOAD(CELL_PAYLOAD)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pdu_start(pdu_start),
    .last_cell(last_cell),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .phase    (phase),
    .idx      (idx),
    .hdr_xfer (hdr_xfer),
    .cell_done(cell_done)
  );

  // header byte as sent, end-of-message bit forced on the final header byte
  assign hdr_sel     = hdr_bytes[idx[HSEL_W-1:0]];
  assign hdr_is_last = (idx == IDX_W'(HDR_BYTES - 1));
  assign hdr_tx      = hdr_is_last ? eom_patch(hdr_sel, last_cell) : hdr_sel;

  seg_hec_acc u_hec (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (pdu_start | cell_done),
    .step_en  (hdr_xfer),
    .step_byte(hdr_tx),
    .hec_q    (hec_q)
  );

  always_comb begin
    out_data  = 8'h00;
    out_valid = 1'b0;
    unique case (phase)
      PH_HDR: begin
        out_data  = hdr_tx;
        out_valid = 1'b1;
      end
      PH_HEC: begin
        out_data  = hec_q ^ HEC_COSET;
        out_valid = 1'b1;
      end
      PH_PAY: begin
        out_data  = in_data;
        out_valid = in_valid;
      end
      default: ;
    endcase
  end

  assign out_scr_en = (phase == PH_PAY);
  assign in_ready   = (phase == PH_PAY) && out_ready;
  assign out_eop    = (phase == PH_PAY) && last_cell && (idx == IDX_W'(CELL_PAYLOAD - 1));

endmodule

// File: rtl/seg_checker.sv
module seg_checker
  import aal5_seg_pkg::*;
#(
  parameter int unsigned HDR_BYTES    = 4,
  parameter int unsigned CELL_PAYLOAD = 48
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_scr_en,
  input logic       out_eop,
  input logic       out_ready,
  input logic       last_cell
);
  localparam int unsigned HC_W = $clog2(HDR_BYTES + 2);
  localparam int unsigned PC_W = $clog2(CELL_PAYLOAD + 1);

  logic [HC_W-1:0] hdr_cnt;
  logic [PC_W-1:0] pay_cnt;
  logic            xfer;

  assign xfer = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_cnt <= '0;
      pay_cnt <= '0;
    end else if (xfer) begin
      if (out_scr_en) begin
        pay_cnt <= pay_cnt + 1'b1;
        hdr_cnt <= '0;
      end else begin
        hdr_cnt <= hdr_cnt + 1'b1;
        pay_cnt <= '0;
      end
    end
  end

  p_hdr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_scr_en && !out_ready |=> out_valid && !out_scr_en && $stable(out_data));

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> out_valid && out_ready && (out_data == in_data));

  p_hdr_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !out_scr_en |-> hdr_cnt < HC_W'(HDR_BYTES + 1));

  p_pay_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && out_scr_en && (pay_cnt == '0) |-> hdr_cnt == HC_W'(HDR_BYTES + 1));

  p_pay_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && out_scr_en |-> pay_cnt < PC_W'(CELL_PAYLOAD));

  p_eop_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> out_scr_en && (pay_cnt == PC_W'(CELL_PAYLOAD - 1)));

  p_eop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop && xfer |=> !out_valid && !in_ready);

  p_eom_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_scr_en && (hdr_cnt == HC_W'(HDR_BYTES - 1))
      |-> (((out_data & EOM_MASK) != 8'h00) == last_cell));

endmodule

bind aal5_cell_seg seg_checker #(
  .HDR_BYTES   (HDR_BYTES),
  .CELL_PAYLOAD(CELL_PAYLOAD)
) u_seg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_scr_en(out_scr_en),
  .out_eop   (out_eop),
  .out_ready (out_ready),
  .last_cell (last_cell)
);

// File: tb/tb_aal5_cell_seg.sv
module tb_aal5_cell_seg;
  localparam int CELL = 48;
  localparam int CLEN = 53;
  localparam int MAXC = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_byte;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_scr_en;
  logic       out_eop;
  logic       out_ready;

  always #10 clk = ~clk;

  aal5_cell_seg dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_byte  (cfg_byte),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_scr_en(out_scr_en),
    .out_eop   (out_eop),
    .out_ready (out_ready)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;

  logic [7:0] pay   [0:CELL*MAXC-1];
  logic [7:0] exp_d [0:CLEN*MAXC-1];
  bit         exp_s [0:CLEN*MAXC-1];
  bit         exp_e [0:CLEN*MAXC-1];
  int         n_exp;
  int         n_pay;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // header check by polynomial long division of header * x^8
  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [39:0] m;
    m = {h, 8'h00};
    for (int b = 39; b >= 8; b--) begin
      if (m[b]) m[b -: 9] = m[b -: 9] ^ 9'h107;
    end
    return m[7:0] ^ 8'h55;
  endfunction

  task automatic push(input logic [7:0] d, input bit s, input bit e);
    exp_d[n_exp] = d;
    exp_s[n_exp] = s;
    exp_e[n_exp] = e;
    n_exp++;
  endtask

  task automatic build(input logic [31:0] hdr, input int ncell);
    logic [7:0]  b3;
    logic [31:0] hv;
    n_pay = ncell * CELL;
    for (int i = 0; i < n_pay; i++) pay[i] = 8'($urandom);
    n_exp = 0;
    for (int c = 0; c < ncell; c++) begin
      b3 = (c == ncell - 1) ? (hdr[7:0] | 8'h02) : (hdr[7:0] & 8'hFD);
      hv = {hdr[31:8], b3};
      push(hv[31:24], 0, 0);
      push(hv[23:16], 0, 0);
      push(hv[15:8], 0, 0);
      push(hv[7:0], 0, 0);
      push(ref_hec(hv), 0, 0);
      for (int k = 0; k < CELL; k++)
        push(pay[c*CELL+k], 1, (c == ncell - 1) && (k == CELL - 1));
    end
  endtask

  task automatic run_pdu(input logic [31:0] hdr, input int ncell,
                         input int vprob, input int rprob, input bit noise);
    logic [15:0] len;
    logic [7:0]  cfgv [0:5];
    logic [7:0]  prev_data;
    bit          prev_hold;
    bit          took;
    int          got, src, cyc, pos, bad0;
    string       dreq;
    build(hdr, ncell);
    len = 16'(ncell * CELL);
    cfgv[0] = hdr[31:24]; cfgv[1] = hdr[23:16]; cfgv[2] = hdr[15:8]; cfgv[3] = hdr[7:0];
    cfgv[4] = len[15:8];  cfgv[5] = len[7:0];
    bad0 = n_bad;
    got = 0; src = 0; cyc = 0; prev_hold = 0; prev_data = 0; took = 0;
    // R1: six configuration bytes in order, the last starts the PDU
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      cfg_we   = 1'b1;
      cfg_byte = cfgv[i];
      in_valid = 1'b0;
      out_ready = ($urandom % 100) < rprob;
    end
    @(posedge clk); #1;
    cfg_we = 1'b0;
    while (got < n_exp && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (prev_hold) chk(out_valid && out_data == prev_data, "R8 header hold", out_data, prev_data);
      prev_hold = out_valid && !out_ready && !out_scr_en;
      prev_data = out_data;
      if (out_scr_en && !in_valid) chk(!out_valid, "R8 payload gap", out_valid, 0);
      if (!out_ready) chk(!in_ready, "R8 backpressure", in_ready, 0);
      if (out_valid && out_ready) begin
        pos = got % CLEN;
        dreq = (pos == 3) ? "R5 eom byte" : (pos == 4) ? "R4 hec" : "R2 cell byte";
        chk(out_data == exp_d[got], dreq, out_data, exp_d[got]);
        chk(out_scr_en == exp_s[got], "R3 scramble flag", out_scr_en, exp_s[got]);
        chk(out_eop == exp_e[got], "R7 end marker", out_eop, exp_e[got]);
        got++;
      end
      took = in_valid && in_ready;
      if (took) src++;
      @(posedge clk); #1;
      cfg_we   = noise && (got < n_exp) && (($urandom % 4) == 0);
      cfg_byte = 8'($urandom);
      if (!(in_valid && !took)) in_valid = (src < n_pay) && (($urandom % 100) < vprob);
      in_data   = (src < n_pay) ? pay[src] : 8'h00;
      out_ready = (got >= n_exp) || (($urandom % 100) < rprob);
    end
    chk(got == n_exp, "R6 cell count", got, n_exp);
    cfg_we = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk(!out_valid && !in_ready && !out_eop && !out_scr_en, "R6 idle after PDU",
        {out_valid, in_ready, out_eop, out_scr_en}, 0);
    chk(src == n_pay, "R6 bytes taken", src, n_pay);
    if (noise) chk(n_bad == bad0, "R1 writes during PDU ignored", n_bad - bad0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC7_0A15));
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_byte = 8'h00;
    in_valid = 1'b0; in_data = 8'h00;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R9: outputs quiet in reset
    chk(!out_valid && !in_ready && !out_scr_en && !out_eop, "R9 reset state",
        {out_valid, in_ready, out_scr_en, out_eop}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !in_ready, "R9 idle after reset", {out_valid, in_ready}, 0);

    // directed: two cells, no stalls, clear end-of-message bit loaded
    run_pdu(32'h0012_3450, 2, 100, 100, 0);
    // directed: end-of-message bit preloaded, must be cleared on earlier cells (R5)
    run_pdu(32'hA5C3_7E3A, 3, 70, 60, 0);
    // directed: heavy stalls with configuration noise during the PDU (R1, R8)
    run_pdu(32'h0101_0102, 2, 30, 30, 1);
    // directed: all-ones header, longest PDU
    run_pdu(32'hFFFF_FFFF, MAXC, 80, 90, 0);
    // random mix
    for (int t = 0; t < 4; t++) begin
      run_pdu($urandom, 2 + int'($urandom % 3), 40 + int'($urandom % 60),
              40 + int'($urandom % 60), bit'($urandom % 2));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule